// File: doc/BRIEF.md
# Serial Character Transmitter with Flags and Interrupt Requests

This block is the transmit half of an asynchronous serial port. Software sets it up through six byte-wide registers: a data register, two control registers, a status register and the low and high bytes of a 16-bit bit-rate divisor. Each accepted write to the data register sends one character on `txd_o`. The character length is 5 to 9 bits, parity is optional (even or odd) and the frame ends with one or two stop bits.

Two flags report progress. The empty flag shows that the data register can take a new character. The done flag shows that the whole frame, stop bits included, has left the pin. Each flag drives an interrupt request. A request is raised only when its own enable bit and the global interrupt enable `gie` are both set. A pulse on `irq_done_ack` acknowledges the done interrupt.

A frame is built by a state machine with states IDLE, START, DATA, PARITY and STOP. Its transitions are:
- **launch**: IDLE to START, on an accepted data write.
- **start_end**: START to DATA, at the end of the start bit.
- **data_to_parity**: DATA to PARITY, after the last data bit when parity is on.
- **data_to_stop**: DATA to STOP, after the last data bit when parity is off.
- **parity_end**: PARITY to STOP.
- **frame_end**: STOP to IDLE, after the last stop bit. This transition sets both flags.

Top module: `sertx_unit`

Register addresses: 0 data, 1 control B, 2 control C, 3 status, 4 divisor low byte, 5 divisor high byte.

## Requirements
- R1: After reset the status register reads 0x20 (only the empty flag set), `txd_o` is high, both requests are low, and control C selects 8 data bits, 1 stop bit and no parity.
- R2: The line idles high. A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then high stop bits.
- R3: The data length comes from a 3-bit size code. Its top bit is control B bit 2 and its two low bits are control C bits 2:1. Codes 0, 1, 2, 3 and 7 give 5, 6, 7, 8 and 9 data bits, and codes 4 to 6 give 8. In 9-bit mode the ninth data bit is control B bit 0, taken when the data write is accepted.
- R4: Control C bit 5 enables parity. Control C bit 4 selects odd parity when 1 and even parity when 0. Parity covers the data bits only, including the ninth bit.
- R5: Control C bit 3 set gives two stop bits. Clear, it gives one.
- R6: Every bit lasts M*(D+1) clocks. D is {divisor high, divisor low}. M is 8 when status bit 1 (double speed) is set and 16 otherwise.
- R7: An accepted data write clears status bit 5 (empty) and status bit 6 (done), seen one clock after the write edge. Both flags set again exactly N*bit-time clocks after the write edge, where N counts every symbol of the frame.
- R8: A data write while a frame is in progress is ignored. The frame in flight, its completion time and the flags are unchanged, and no further frame follows.
- R9: Writing control B with bit 3 (transmit enable) set, while that bit was clear, sets the empty flag.
- R10: `irq_done_o` is high when the done flag, control B bit 6 and `gie` are all set. A pulse on `irq_done_ack` clears the done flag.
- R11: `irq_empty_o` is high when the empty flag, control B bit 5 and `gie` are all set.
- R12: With divisor 103 at normal speed and an 8-data-bit, no-parity, one-stop-bit frame, the done flag sets 16640 clocks after the data write (1.04 ms at 16 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| gie | input | 1 | Global interrupt enable |
| irq_done_ack | input | 1 | Done interrupt acknowledge; clears the done flag |
| txd_o | output | 1 | Serial output |
| status_o | output | 8 | Status register: bit 6 done, bit 5 empty, bit 1 double speed |
| irq_empty_o | output | 1 | Data-register-empty interrupt request |
| irq_done_o | output | 1 | Transmit-complete interrupt request |

## Verification
The write edge is the clock edge on which a data write is accepted. The flag clears are visible one clock after that edge. Symbol k of the frame drives the line from k bit-times after the write edge. The flags set exactly N bit-times after it. The interrupt requests follow the flags and enables within the same cycle.

The bench drives every write on a falling edge and then counts whole clocks from the write edge. It reads each symbol just after the edge that starts it. It reads the done flag one clock before and one clock after its due edge, so an early or late completion by a single clock is caught. The reference-rate case reads the flag at clock 16639 and at clock 16640.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // register addresses
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTLB = 3'd1;
    localparam logic [2:0] A_CTLC = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_DIVL = 3'd4;
    localparam logic [2:0] A_DIVH = 3'd5;

    // control B fields
    localparam int B_NINTH    = 0;
    localparam int B_SIZE2    = 2;
    localparam int B_TXEN     = 3;
    localparam int B_IE_EMPTY = 5;
    localparam int B_IE_DONE  = 6;

    // control C fields
    localparam int C_SIZE_LO = 1;
    localparam int C_STOP2   = 3;
    localparam int C_PODD    = 4;
    localparam int C_PEN     = 5;

    // status fields
    localparam int S_DBL   = 1;
    localparam int S_EMPTY = 5;
    localparam int S_DONE  = 6;

    function automatic logic [3:0] data_len(input logic [2:0] code);
        case (code)
            3'd0:    data_len = 4'd5;
            3'd1:    data_len = 4'd6;
            3'd2:    data_len = 4'd7;
            3'd7:    data_len = 4'd9;
            default: data_len = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int PER_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             bit_end
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt;

    assign bit_end = run && (cnt == period - ONE);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || bit_end)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              bit_end,
    input  logic [WORD_W-1:0] word,
    input  logic [3:0]        nbits,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              txd,
    output logic              busy,
    output logic              frame_done
);
    tx_state_e         state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [3:0]        bcnt;
    logic [3:0]        nb_q;
    logic              pe_q, two_q, par_q;
    logic [WORD_W-1:0] mask;
    logic              last_data, last_stop;

    assign mask      = (WORD_W'(1) << nbits) - WORD_W'(1);
    assign last_data = (bcnt == nb_q - 4'd1);
    assign last_stop = (bcnt == {3'b000, two_q});

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (launch) state_nx = ST_START;
            ST_START:  if (bit_end) state_nx = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_nx = pe_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_nx = ST_STOP;
            ST_STOP:   if (bit_end && last_stop) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // frame datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
            nb_q  <= 4'd8;
            pe_q  <= 1'b0;
            two_q <= 1'b0;
            par_q <= 1'b0;
        end else if (state == ST_IDLE && launch) begin
            shreg <= word;
            bcnt  <= '0;
            nb_q  <= nbits;
            pe_q  <= par_en;
            two_q <= two_stop;
            par_q <= (^(word & mask)) ^ par_odd;
        end else begin
            if (state != state_nx)
                bcnt <= '0;
            else if (bit_end)
                bcnt <= bcnt + 4'd1;
            if (state == ST_DATA && bit_end)
                shreg <= shreg >> 1;
        end
    end

    // outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        frame_done = 1'b0;
        unique case (state)
            ST_IDLE:   txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            ST_STOP: begin
                txd        = 1'b1;
                frame_done = bit_end && last_stop;
            end
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic frame_done,
    input  logic txen_rise,
    input  logic clr_done,
    output logic empty,
    output logic done
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty <= 1'b1;
            done  <= 1'b0;
        end else begin
            if (frame_done || txen_rise)
                empty <= 1'b1;
            else if (launch)
                empty <= 1'b0;
            if (frame_done)
                done <= 1'b1;
            else if (launch || clr_done)
                done <= 1'b0;
        end
    end
endmodule

// File: rtl/sertx_unit.sv
module sertx_unit
    import sertx_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             gie,
    input  logic             irq_done_ack,
    output logic             txd_o,
    output logic [REG_W-1:0] status_o,
    output logic             irq_empty_o,
    output logic             irq_done_o
);
    localparam int DIV_W  = 2 * REG_W;
    localparam int PER_W  = DIV_W + 5;
    localparam int WORD_W = REG_W + 1;

    logic [REG_W-1:0] ctl_b, ctl_c, div_lo, div_hi;
    logic             dbl;
    logic             busy, bit_end, frame_done, launch, txen_rise;
    logic             flag_empty, flag_done;
    logic [PER_W-1:0] period;
    logic             sel_data, sel_b;

    assign sel_data  = wr_en && (wr_addr == A_DATA);
    assign sel_b     = wr_en && (wr_addr == A_CTLB);
    assign launch    = sel_data && !busy;
    assign txen_rise = sel_b && wr_data[B_TXEN] && !ctl_b[B_TXEN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_b  <= '0;
            ctl_c  <= REG_W'(3) << C_SIZE_LO;
            div_lo <= '0;
            div_hi <= '0;
            dbl    <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTLB:  ctl_b  <= wr_data;
                A_CTLC:  ctl_c  <= wr_data;
                A_STAT:  dbl    <= wr_data[S_DBL];
                A_DIVL:  div_lo <= wr_data;
                A_DIVH:  div_hi <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        period = (PER_W'({div_hi, div_lo}) + PER_W'(1)) << (dbl ? 3 : 4);
    end

    sertx_bit_timer #(.PER_W(PER_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .period  (period),
        .bit_end (bit_end)
    );

    sertx_frame_fsm #(.WORD_W(WORD_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .bit_end    (bit_end),
        .word       ({ctl_b[B_NINTH], wr_data}),
        .nbits      (data_len({ctl_b[B_SIZE2], ctl_c[C_SIZE_LO+1:C_SIZE_LO]})),
        .par_en     (ctl_c[C_PEN]),
        .par_odd    (ctl_c[C_PODD]),
        .two_stop   (ctl_c[C_STOP2]),
        .txd        (txd_o),
        .busy       (busy),
        .frame_done (frame_done)
    );

    sertx_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .frame_done (frame_done),
        .txen_rise  (txen_rise),
        .clr_done   (irq_done_ack),
        .empty      (flag_empty),
        .done       (flag_done)
    );

    always_comb begin
        status_o          = '0;
        status_o[S_DBL]   = dbl;
        status_o[S_EMPTY] = flag_empty;
        status_o[S_DONE]  = flag_done;
    end

    assign irq_empty_o = flag_empty && ctl_b[B_IE_EMPTY] && gie;
    assign irq_done_o  = flag_done && ctl_b[B_IE_DONE] && gie;
endmodule

// File: rtl/sertx_checks.sv
module sertx_checks (
    input logic clk,
    input logic rst_n,
    input logic launch,
    input logic busy,
    input logic bit_end,
    input logic frame_done,
    input logic txd,
    input logic flag_empty,
    input logic flag_done,
    input logic ack
);
    // R2: line is high whenever no frame is running
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R2: the first symbol of every frame is low
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    // R6: the line only changes at a bit boundary
    assert_hold_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> $stable(txd));

    // R7: an accepted write clears both flags
    assert_launch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (!flag_empty && !flag_done));

    // R7: done rises only from the end of a frame
    assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> $past(frame_done));

    // R10: acknowledge clears done
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !frame_done) |=> !flag_done);
endmodule

bind sertx_unit sertx_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .busy       (busy),
    .bit_end    (bit_end),
    .frame_done (frame_done),
    .txd        (txd_o),
    .flag_empty (flag_empty),
    .flag_done  (flag_done),
    .ack        (irq_done_ack)
);

// File: tb/test_sertx_unit.sv
module test_sertx_unit;

    localparam logic [2:0] RA_DATA = 3'd0, RA_B = 3'd1, RA_C = 3'd2,
                           RA_ST = 3'd3, RA_DL = 3'd4, RA_DH = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       gie = 1'b0;
    logic       irq_done_ack = 1'b0;
    logic       txd_o;
    logic [7:0] status_o;
    logic       irq_empty_o, irq_done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sertx_unit i_sertx_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .gie          (gie),
        .irq_done_ack (irq_done_ack),
        .txd_o        (txd_o),
        .status_o     (status_o),
        .irq_empty_o  (irq_empty_o),
        .irq_done_o   (irq_done_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // send one character and check every symbol and the flag timing
    task automatic send(input string req, input logic [8:0] d, input int nb,
                        input bit pe, input bit odd, input bit two,
                        input int t, input int poke);
        logic sym [0:15];
        int   n;
        logic p;
        n = 0;
        p = odd;
        sym[n++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            sym[n++] = d[i];
            p = p ^ d[i];
        end
        if (pe) sym[n++] = p;
        sym[n++] = 1'b1;
        if (two) sym[n++] = 1'b1;
        wr(RA_DATA, d[7:0]);
        chk("R7", "empty after write", 32'(status_o[5]), 32'd0);
        chk("R7", "done after write", 32'(status_o[6]), 32'd0);
        for (int i = 0; i < n; i++) begin
            chk(req, $sformatf("symbol %0d", i), 32'(txd_o), 32'(sym[i]));
            if (i == n - 1) begin
                repeat (t - 1) @(negedge clk);
            end else if (i == poke) begin
                wr(RA_DATA, 8'hFF);
                repeat (t - 2) @(negedge clk);
            end else begin
                repeat (t) @(negedge clk);
            end
        end
        chk("R7", "done one clock early", 32'(status_o[6]), 32'd0);
        @(negedge clk);
        chk("R7", "done at frame end", 32'(status_o[6]), 32'd1);
        chk("R7", "empty at frame end", 32'(status_o[5]), 32'd1);
        chk("R2", "idle after frame", 32'(txd_o), 32'd1);
    endtask

    task automatic set_rate(input logic [7:0] hi, input logic [7:0] lo, input bit dbl);
        wr(RA_DH, hi);
        wr(RA_DL, lo);
        wr(RA_ST, {6'd0, dbl, 1'b0});
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "status", 32'(status_o), 32'h20);
        chk("R1", "txd", 32'(txd_o), 32'd1);
        chk("R1", "irq_empty", 32'(irq_empty_o), 32'd0);
        chk("R1", "irq_done", 32'(irq_done_o), 32'd0);
        set_rate(8'd0, 8'd1, 1'b0);
        send("R1", 9'h0A5, 8, 1'b0, 1'b0, 1'b0, 32, -1);
    endtask

    task automatic t_sizes;
        wr(RA_B, 8'h00);
        wr(RA_C, 8'h00);
        send("R3", 9'h0B3, 5, 1'b0, 1'b0, 1'b0, 32, -1);
        wr(RA_C, 8'h02);
        send("R3", 9'h0B3, 6, 1'b0, 1'b0, 1'b0, 32, -1);
        wr(RA_C, 8'h04);
        send("R3", 9'h0B3, 7, 1'b0, 1'b0, 1'b0, 32, -1);
        wr(RA_C, 8'h06);
        send("R3", 9'h0B3, 8, 1'b0, 1'b0, 1'b0, 32, -1);
        wr(RA_B, 8'h05);
        send("R3", 9'h1B3, 9, 1'b0, 1'b0, 1'b0, 32, -1);
        wr(RA_C, 8'h02);
        send("R3", 9'h0B3, 8, 1'b0, 1'b0, 1'b0, 32, -1);
        wr(RA_B, 8'h00);
    endtask

    task automatic t_parity;
        wr(RA_C, 8'h24);
        send("R4", 9'h035, 7, 1'b1, 1'b0, 1'b0, 32, -1);
        wr(RA_C, 8'h34);
        send("R4", 9'h035, 7, 1'b1, 1'b1, 1'b0, 32, -1);
        wr(RA_B, 8'h05);
        wr(RA_C, 8'h26);
        send("R4", 9'h101, 9, 1'b1, 1'b0, 1'b0, 32, -1);
        wr(RA_B, 8'h00);
    endtask

    task automatic t_stop;
        wr(RA_C, 8'h0E);
        send("R5", 9'h0C6, 8, 1'b0, 1'b0, 1'b1, 32, -1);
        wr(RA_C, 8'h38);
        send("R5", 9'h013, 5, 1'b1, 1'b1, 1'b1, 32, -1);
    endtask

    task automatic t_speed;
        wr(RA_C, 8'h06);
        set_rate(8'd0, 8'd0, 1'b1);
        send("R6", 9'h03C, 8, 1'b0, 1'b0, 1'b0, 8, -1);
        set_rate(8'd0, 8'd2, 1'b0);
        send("R6", 9'h0E1, 8, 1'b0, 1'b0, 1'b0, 48, -1);
        set_rate(8'd1, 8'd0, 1'b1);
        send("R6", 9'h05A, 8, 1'b0, 1'b0, 1'b0, 2056, -1);
        set_rate(8'd0, 8'd1, 1'b0);
    endtask

    task automatic t_busy_write;
        send("R8", 9'h055, 8, 1'b0, 1'b0, 1'b0, 32, 3);
        repeat (64) begin
            @(negedge clk);
            chk("R8", "no second frame", 32'(txd_o), 32'd1);
        end
        chk("R8", "flags after ignored write", 32'(status_o[6:5]), 32'h3);
    endtask

    task automatic t_txen;
        wr(RA_B, 8'h00);
        wr(RA_DATA, 8'h11);
        repeat (5) @(negedge clk);
        chk("R9", "empty mid-frame", 32'(status_o[5]), 32'd0);
        wr(RA_B, 8'h08);
        chk("R9", "empty after enable rise", 32'(status_o[5]), 32'd1);
        chk("R9", "done untouched", 32'(status_o[6]), 32'd0);
        repeat (400) @(negedge clk);
        chk("R9", "frame completed", 32'(status_o[6]), 32'd1);
    endtask

    task automatic t_irq;
        wr(RA_B, 8'h48);
        gie = 1'b0;
        send("R10", 9'h077, 8, 1'b0, 1'b0, 1'b0, 32, -1);
        chk("R10", "irq_done with gie low", 32'(irq_done_o), 32'd0);
        gie = 1'b1;
        @(negedge clk);
        chk("R10", "irq_done raised", 32'(irq_done_o), 32'd1);
        irq_done_ack = 1'b1;
        @(negedge clk);
        irq_done_ack = 1'b0;
        chk("R10", "done after ack", 32'(status_o[6]), 32'd0);
        chk("R10", "irq_done after ack", 32'(irq_done_o), 32'd0);
        chk("R10", "empty untouched by ack", 32'(status_o[5]), 32'd1);
        chk("R11", "irq_empty with enable off", 32'(irq_empty_o), 32'd0);
        wr(RA_B, 8'h28);
        chk("R11", "irq_empty raised", 32'(irq_empty_o), 32'd1);
        gie = 1'b0;
        @(negedge clk);
        chk("R11", "irq_empty with gie low", 32'(irq_empty_o), 32'd0);
        gie = 1'b1;
        wr(RA_DATA, 8'h20);
        chk("R11", "irq_empty while sending", 32'(irq_empty_o), 32'd0);
        repeat (330) @(negedge clk);
        chk("R11", "irq_empty after frame", 32'(irq_empty_o), 32'd1);
        gie = 1'b0;
        wr(RA_B, 8'h08);
    endtask

    task automatic t_ref_rate;
        wr(RA_C, 8'h06);
        set_rate(8'd0, 8'd103, 1'b0);
        wr(RA_DATA, 8'h48);
        repeat (16639) @(negedge clk);
        chk("R12", "done at clock 16639", 32'(status_o[6]), 32'd0);
        @(negedge clk);
        chk("R12", "done at clock 16640", 32'(status_o[6]), 32'd1);
    endtask

    initial begin
        t_reset();
        t_sizes();
        t_parity();
        t_stop();
        t_speed();
        t_busy_write();
        t_txen();
        t_irq();
        t_ref_rate();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule